// File: doc/BRIEF.md
# Half-Bridge PWM Generator with Dead-Time Insertion

This block turns a single counter-and-compare pulse train into two gate-drive signals for a half-bridge. One drive feeds the upper switch and the other feeds the lower switch. A prescaler slows the system clock by a programmable ratio. Its ticks advance an up-counter that returns to zero after a programmable top value. A compare value splits each period into an active part, where the counter is below the compare value, and an inactive part. The active part requests the upper switch and the inactive part requests the lower switch.

Each time the request changes, a small state machine holds both drives off for a programmable number of undivided clock cycles before it turns on the incoming side. A request that flips back before that interval ends never reaches its output. This keeps the two switches from conducting together.

The prescale, top, compare and dead-time inputs act as shadow values. The running copies take them at each counter wrap, or continuously while the block is disabled, so a period is never cut short. The state machine has five states:
- `HB_IDLE`: disabled, both drives off.
- `HB_DEAD_RISE`: waiting before the upper drive turns on.
- `HB_HIGH_ON`: upper drive on.
- `HB_DEAD_FALL`: waiting before the lower drive turns on.
- `HB_LOW_ON`: lower drive on.

It has these transitions:
- Any state goes to idle when the enable is low.
- Idle goes to a rise or fall wait, chosen by the request.
- An on state goes to the opposite wait when the request flips.
- A wait goes to the opposite wait when the request flips back.
- A wait goes to its on state once the dead count is reached.
- With a dead time of zero, the waits are skipped and the block moves straight to an on state.

Top module: `halfbridge_pwm`

## Requirements
- R1: The counter advances once every `psc_in`+1 clock cycles. The prescale count never exceeds the running prescale value.
- R2: The counter runs 0 to `arr_in` and wraps. A PWM period lasts (`psc_in`+1)×(`arr_in`+1) clock cycles, measured between rising edges of `gate_hi`.
- R3: The request is high while the count is below `ccr_in`. When the active part is longer than the dead time, `gate_hi` is high for `ccr_in`×(`psc_in`+1) − `dt_in` clocks per period. `gate_lo` is high for (`arr_in`+1−`ccr_in`)×(`psc_in`+1) − `dt_in` clocks per period.
- R4: `gate_hi` and `gate_lo` are never high in the same cycle.
- R5: With a nonzero `dt_in`, both drives are low for exactly `dt_in` clock cycles at every transition, whether the upper side turns off or the lower side turns off.
- R6: With `dt_in` = 0 and the block enabled, `gate_lo` is the exact complement of `gate_hi` from the second enabled cycle onward.
- R7: A request pulse lasting `dt_in` clock cycles or fewer never appears on its output.
- R8: `ccr_in` = 0 keeps `gate_hi` low, with `gate_lo` steadily high. `ccr_in` > `arr_in` keeps `gate_hi` steadily high, with `gate_lo` low.
- R9: A change to `ccr_in` while the block runs leaves the current period unchanged and takes effect from the next counter wrap.
- R10: During reset, or in the cycle after `en` goes low, both drives are low and both counters are zero.
- R11: After `en` rises, the first drive turns on at the (`dt_in`+1)-th clock edge that sees `en` high. The counter starts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces both drives off and clears the counters |
| psc_in | input | PSC_W | Prescale shadow value (divide by value+1) |
| arr_in | input | CNT_W | Counter top shadow value |
| ccr_in | input | CNT_W | Compare shadow value |
| dt_in | input | DT_W | Dead-time shadow value in clock cycles |
| gate_hi | output | 1 | Upper switch drive |
| gate_lo | output | 1 | Lower switch drive |

## Verification
The bench drives a cycle-accurate behavioural model alongside the design and targets these corner cases:
- Request pulses no longer than the dead time: a design that counted one cycle short would leak a one-cycle sliver onto the output.
- A dead time of zero: an off-by-one there would insert a stray gap or let the two drives overlap.
- Compare values of zero and above the top value: these check that no phantom edge or dead gap appears.
- A compare change in mid-period: a design that loaded it immediately would truncate the running pulse.
- Disabling mid-pulse and the wait after enabling: a design with stale counter or state would start at the wrong phase or light a drive early.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;

    typedef enum logic [2:0] {
        HB_IDLE      = 3'd0,
        HB_DEAD_RISE = 3'd1,
        HB_HIGH_ON   = 3'd2,
        HB_DEAD_FALL = 3'd3,
        HB_LOW_ON    = 3'd4
    } hb_state_e;

endpackage

// File: rtl/hb_prescaler.sv
module hb_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] limit,
    output logic [PSC_W-1:0] pre_cnt,
    output logic             tick
);
    localparam logic [PSC_W-1:0] PRE_ZERO = '0;
    localparam logic [PSC_W-1:0] PRE_ONE  = PSC_W'(1);

    assign tick = run && (pre_cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= PRE_ZERO;
        end else if (!run || tick) begin
            pre_cnt <= PRE_ZERO;
        end else begin
            pre_cnt <= pre_cnt + PRE_ONE;
        end
    end

endmodule

// File: rtl/hb_shadow_bank.sv
module hb_shadow_bank #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wrap,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] arr_in,
    input  logic [CNT_W-1:0] ccr_in,
    input  logic [DT_W-1:0]  dt_in,
    output logic [PSC_W-1:0] psc_act,
    output logic [CNT_W-1:0] arr_act,
    output logic [CNT_W-1:0] ccr_act,
    output logic [DT_W-1:0]  dt_act
);
    logic take;

    // Running copies follow the shadows while idle and at each wrap only.
    assign take = !run || wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_act <= '0;
            arr_act <= '0;
            ccr_act <= '0;
            dt_act  <= '0;
        end else if (take) begin
            psc_act <= psc_in;
            arr_act <= arr_in;
            ccr_act <= ccr_in;
            dt_act  <= dt_in;
        end
    end

endmodule

// File: rtl/hb_period_counter.sv
module hb_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] arr_act,
    input  logic [CNT_W-1:0] ccr_act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             req_hi
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    assign wrap   = tick && (cnt == arr_act);
    assign req_hi = run && (cnt < ccr_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_ZERO;
        end else if (!run || wrap) begin
            cnt <= CNT_ZERO;
        end else if (tick) begin
            cnt <= cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/hb_deadtime_fsm.sv
module hb_deadtime_fsm
    import hb_pwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            req_hi,
    input  logic [DT_W-1:0] dt_act,
    output logic            gate_hi,
    output logic            gate_lo
);
    localparam logic [DT_W-1:0] D_ZERO = '0;
    localparam logic [DT_W-1:0] D_ONE  = DT_W'(1);

    hb_state_e       state, state_nx;
    logic [DT_W-1:0] dcnt, dcnt_nx;
    hb_state_e       rise_tgt, fall_tgt;
    logic [DT_W-1:0] entry_cnt;
    logic            no_gap;

    assign no_gap    = (dt_act == D_ZERO);
    assign rise_tgt  = no_gap ? HB_HIGH_ON : HB_DEAD_RISE;
    assign fall_tgt  = no_gap ? HB_LOW_ON  : HB_DEAD_FALL;
    assign entry_cnt = no_gap ? D_ZERO : D_ONE;

    always_comb begin
        state_nx = state;
        dcnt_nx  = dcnt;
        if (!run) begin
            state_nx = HB_IDLE;
            dcnt_nx  = D_ZERO;
        end else begin
            unique case (state)
                HB_IDLE: begin
                    state_nx = req_hi ? rise_tgt : fall_tgt;
                    dcnt_nx  = entry_cnt;
                end
                HB_HIGH_ON: begin
                    if (!req_hi) begin
                        state_nx = fall_tgt;
                        dcnt_nx  = entry_cnt;
                    end
                end
                HB_LOW_ON: begin
                    if (req_hi) begin
                        state_nx = rise_tgt;
                        dcnt_nx  = entry_cnt;
                    end
                end
                HB_DEAD_RISE: begin
                    if (!req_hi) begin
                        state_nx = fall_tgt;
                        dcnt_nx  = entry_cnt;
                    end else if (dcnt >= dt_act) begin
                        state_nx = HB_HIGH_ON;
                        dcnt_nx  = D_ZERO;
                    end else begin
                        dcnt_nx  = dcnt + D_ONE;
                    end
                end
                HB_DEAD_FALL: begin
                    if (req_hi) begin
                        state_nx = rise_tgt;
                        dcnt_nx  = entry_cnt;
                    end else if (dcnt >= dt_act) begin
                        state_nx = HB_LOW_ON;
                        dcnt_nx  = D_ZERO;
                    end else begin
                        dcnt_nx  = dcnt + D_ONE;
                    end
                end
                default: begin
                    state_nx = HB_IDLE;
                    dcnt_nx  = D_ZERO;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HB_IDLE;
            dcnt  <= D_ZERO;
        end else begin
            state <= state_nx;
            dcnt  <= dcnt_nx;
        end
    end

    // Registered drives decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= (state_nx == HB_HIGH_ON);
            gate_lo <= (state_nx == HB_LOW_ON);
        end
    end

endmodule

// File: rtl/halfbridge_pwm.sv
module halfbridge_pwm #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] arr_in,
    input  logic [CNT_W-1:0] ccr_in,
    input  logic [DT_W-1:0]  dt_in,
    output logic             gate_hi,
    output logic             gate_lo
);
    logic [PSC_W-1:0] psc_act;
    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] ccr_act;
    logic [DT_W-1:0]  dt_act;
    logic [PSC_W-1:0] pre_cnt;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             wrap;
    logic             req_hi;

    hb_shadow_bank #(
        .PSC_W(PSC_W), .CNT_W(CNT_W), .DT_W(DT_W)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .run(en), .wrap(wrap),
        .psc_in(psc_in), .arr_in(arr_in), .ccr_in(ccr_in), .dt_in(dt_in),
        .psc_act(psc_act), .arr_act(arr_act), .ccr_act(ccr_act), .dt_act(dt_act)
    );

    hb_prescaler #(
        .PSC_W(PSC_W)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .run(en), .limit(psc_act),
        .pre_cnt(pre_cnt), .tick(tick)
    );

    hb_period_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(en), .tick(tick),
        .arr_act(arr_act), .ccr_act(ccr_act),
        .cnt(cnt), .wrap(wrap), .req_hi(req_hi)
    );

    hb_deadtime_fsm #(
        .DT_W(DT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(en), .req_hi(req_hi), .dt_act(dt_act),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

endmodule

// File: rtl/hb_pwm_checker.sv
module hb_pwm_checker #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             gate_hi,
    input logic             gate_lo,
    input logic [PSC_W-1:0] pre_cnt,
    input logic [PSC_W-1:0] psc_act,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] arr_act,
    input logic [CNT_W-1:0] ccr_act,
    input logic [DT_W-1:0]  dt_act,
    input logic             wrap
);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate_hi && !gate_lo && cnt == '0 && pre_cnt == '0));

    assert_gap_before_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) && $past(dt_act) != '0) |-> !$past(gate_lo));

    assert_gap_before_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lo) && $past(dt_act) != '0) |-> !$past(gate_hi));

    assert_prescale_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= psc_act);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= arr_act);

    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !$past(wrap)) |-> ($stable(ccr_act) && $stable(arr_act)));

    assert_zero_compare_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en && ccr_act == '0) |-> !gate_hi);

endmodule

bind halfbridge_pwm hb_pwm_checker #(
    .PSC_W(PSC_W), .CNT_W(CNT_W), .DT_W(DT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .pre_cnt(pre_cnt), .psc_act(psc_act), .cnt(cnt), .arr_act(arr_act),
    .ccr_act(ccr_act), .dt_act(dt_act), .wrap(wrap)
);

// File: tb/test_halfbridge_pwm.sv
module test_halfbridge_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int PSC_W = 16;
    localparam int CNT_W = 16;
    localparam int DT_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [PSC_W-1:0] psc_in = '0;
    logic [CNT_W-1:0] arr_in = '0;
    logic [CNT_W-1:0] ccr_in = '0;
    logic [DT_W-1:0]  dt_in = '0;
    logic             gate_hi, gate_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    halfbridge_pwm #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DT_W(DT_W)) i_halfbridge_pwm (
        .clk(clk), .rst_n(rst_n), .en(en), .psc_in(psc_in), .arr_in(arr_in),
        .ccr_in(ccr_in), .dt_in(dt_in), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated at each rising edge
    int m_pre = 0, m_cnt = 0, m_psc = 0, m_arr = 0, m_ccr = 0, m_dt = 0, m_run = 0;
    bit m_last = 0, m_hs = 0, m_ls = 0;

    always @(posedge clk) begin
        bit r;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_psc = 0; m_arr = 0; m_ccr = 0; m_dt = 0;
            m_run = 0; m_hs = 0; m_ls = 0;
        end else if (!en) begin
            m_pre = 0; m_cnt = 0; m_run = 0; m_hs = 0; m_ls = 0;
            m_psc = psc_in; m_arr = arr_in; m_ccr = ccr_in; m_dt = dt_in;
        end else begin
            r = (m_cnt < m_ccr);
            if (m_run > 0 && r == m_last) m_run++;
            else m_run = 1;
            m_last = r;
            m_hs = r && (m_hs || m_run > m_dt);
            m_ls = !r && (m_ls || m_run > m_dt);
            if (m_pre == m_psc) begin
                m_pre = 0;
                if (m_cnt == m_arr) begin
                    m_cnt = 0;
                    m_psc = psc_in; m_arr = arr_in; m_ccr = ccr_in; m_dt = dt_in;
                end else begin
                    m_cnt++;
                end
            end else begin
                m_pre++;
            end
        end
    end

    // Per-cycle comparison against the model (R3, R5, R7) and overlap (R4)
    always @(negedge clk) begin
        if (!done) begin
            chk(gate_hi == m_hs, "R3 R5 R7 model gate_hi", int'(gate_hi), int'(m_hs));
            chk(gate_lo == m_ls, "R3 R5 R7 model gate_lo", int'(gate_lo), int'(m_ls));
            chk(!(gate_hi && gate_lo), "R4 overlap", int'(gate_hi && gate_lo), 0);
        end
    end

    task automatic setup(input int p, input int a, input int c, input int d);
        @(negedge clk);
        en = 1'b0;
        psc_in = PSC_W'(p); arr_in = CNT_W'(a); ccr_in = CNT_W'(c); dt_in = DT_W'(d);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic measure(input int n, output int hi, output int lo, output int dead);
        hi = 0; lo = 0; dead = 0;
        repeat (n) begin
            @(negedge clk);
            if (gate_hi) hi++;
            if (gate_lo) lo++;
            if (!gate_hi && !gate_lo) dead++;
        end
    endtask

    task automatic next_rise(output int waited);
        bit p, rose;
        waited = 0;
        p = gate_hi;
        rose = 0;
        while (!rose && waited < 20000) begin
            @(negedge clk);
            waited++;
            rose = !p && gate_hi;
            p = gate_hi;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R2 actual=timeout expected=finish");
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int hi, lo, dead, w, len, k;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R10 reset drives", int'(gate_hi) + int'(gate_lo), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!gate_hi && !gate_lo, "R10 disabled drives", int'(gate_hi) + int'(gate_lo), 0);

        // R11: enable entry waits dt+1 edges
        setup(0, 9, 5, 3);
        k = 0;
        do begin @(negedge clk); k++; end while (!gate_hi && k < 50);
        chk(k == 4, "R11 first on after enable", k, 4);

        // R2/R3/R5: psc=1 arr=9 ccr=4 dt=2
        setup(1, 9, 4, 2);
        repeat (60) @(negedge clk);
        measure(100, hi, lo, dead);
        chk(hi == 30, "R3 high time", hi, 30);
        chk(lo == 50, "R3 low time", lo, 50);
        chk(dead == 20, "R5 dead time both edges", dead, 20);
        next_rise(w); next_rise(w);
        chk(w == 20, "R2 period", w, 20);

        // R10: disable mid-run
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!gate_hi && !gate_lo, "R10 disable clears drives", int'(gate_hi) + int'(gate_lo), 0);

        // R1: prescale by 4
        setup(3, 4, 2, 1);
        repeat (45) @(negedge clk);
        measure(40, hi, lo, dead);
        chk(hi == 14, "R1 high time", hi, 14);
        chk(lo == 22, "R1 low time", lo, 22);
        next_rise(w); next_rise(w);
        chk(w == 20, "R1 period", w, 20);

        // R6: zero dead time gives exact complements
        setup(0, 7, 3, 0);
        @(negedge clk);
        len = 0; hi = 0;
        repeat (64) begin
            @(negedge clk);
            if (gate_hi == gate_lo) len++;
            if (gate_hi) hi++;
        end
        chk(len == 0, "R6 complement mismatches", len, 0);
        chk(hi == 24, "R6 high time", hi, 24);

        // R7: short pulse suppressed
        setup(0, 9, 2, 3);
        repeat (30) @(negedge clk);
        measure(50, hi, lo, dead);
        chk(hi == 0, "R7 short pulse suppressed", hi, 0);
        chk(lo == 25, "R7 low side kept", lo, 25);

        // R8: compare at zero and above top
        setup(0, 9, 0, 4);
        repeat (20) @(negedge clk);
        measure(30, hi, lo, dead);
        chk(hi == 0 && lo == 30, "R8 compare zero", hi * 100 + lo, 30);
        setup(0, 9, 20, 4);
        repeat (20) @(negedge clk);
        measure(30, hi, lo, dead);
        chk(hi == 30 && lo == 0, "R8 compare above top", hi * 100 + lo, 3000);

        // R9: compare change lands at the next wrap
        setup(0, 9, 5, 1);
        repeat (25) @(negedge clk);
        next_rise(w);
        ccr_in = CNT_W'(2);
        len = 1;
        forever begin
            @(negedge clk);
            if (gate_hi) len++;
            else break;
        end
        chk(len == 4, "R9 running pulse kept", len, 4);
        next_rise(w);
        len = 1;
        forever begin
            @(negedge clk);
            if (gate_hi) len++;
            else break;
        end
        chk(len == 1, "R9 new compare next period", len, 1);

        // R2/R3: 1/4200 rate, half duty, dt=10
        setup(83, 49, 25, 10);
        next_rise(w); next_rise(w);
        chk(w == 4200, "R2 long period", w, 4200);
        measure(4200, hi, lo, dead);
        chk(hi == 2090, "R3 long high time", hi, 2090);
        chk(lo == 2090, "R3 long low time", lo, 2090);
        chk(dead == 20, "R5 long dead time", dead, 20);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule